// File: doc/BRIEF.md
# Serial DAC Input Register Controller

This block is the digital front end of a 12-bit voltage-output converter. A host writes it over a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. The block runs on its own system clock. It oversamples all three wires through synchronizers and acts on the edges it detects.

A frame opens only when the strobe falls. Each falling serial-clock edge then captures one bit, most significant first. The first two bits carry no meaning, the next two select the operating mode, and the last twelve are the straight-binary converter code. When the sixteenth bit arrives, the new code and mode are applied together with a one-cycle update strobe. The ideal analog output is then code/4096 of the reference. Mode zero is normal operation. The other three modes are separate power-down variants, and each one is reported on its own select line.

A frame that is cut short by the strobe rising is thrown away. Once a frame has completed, further serial-clock edges are ignored until the strobe has gone high and falls again.

Top module: `dac_serial_front`

## Requirements
- R1: After reset, code_o is 0, mode_o is 0 (normal), pd_active_o is 0, pd_sel_o is 0 and update_o is 0.
- R2: A frame of 16 bits, sent MSB first while sync_n_i stays low, sets code_o to bits [11:0] of the word and mode_o to bits [13:12], taking effect from the sixteenth falling sclk_i edge.
- R3: Word bits [15:14] (the first two bits sent) have no effect on any output.
- R4: The mode is decoded as follows. Mode 0 gives pd_active_o = 0 and pd_sel_o = 3'b000. Mode m in 1..3 gives pd_active_o = 1 and pd_sel_o with only bit m-1 set.
- R5: If sync_n_i rises before the sixteenth falling sclk_i edge, the partial frame is discarded: code_o and mode_o keep their old values and no update pulse occurs. The outputs also stay unchanged while a frame is still incomplete.
- R6: After the sixteenth edge, further falling sclk_i edges with sync_n_i still low change nothing and cause no second update.
- R7: update_o is high for exactly one clock for each completed frame. code_o and mode_o change only in that cycle.
- R8: Falling sclk_i edges while sync_n_i is high are ignored. A frame starts only on a falling edge of sync_n_i.
- R9: If sync_n_i is seen rising in the same system cycle as the sixteenth falling sclk_i edge, that edge is not accepted and the frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n_i | input | 1 | Frame strobe, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data captured on its falling edge |
| sdin_i | input | 1 | Serial data, MSB first |
| code_o | output | 12 | Current converter code |
| mode_o | output | 2 | Current operating mode (0 = normal) |
| pd_active_o | output | 1 | High in any power-down mode |
| pd_sel_o | output | 3 | One-hot select of the active power-down variant |
| update_o | output | 1 | One-cycle pulse when a completed frame is applied |

## Verification
Two events can land in the same system cycle: the sixteenth falling serial-clock edge, which would complete a frame, and the strobe rising, which aborts it. The bench provokes this by releasing the strobe on the same driving edge that lowers the serial clock for the final bit. Both wires pass through identical synchronizer depth, so the block sees the two events together. The result is judged by the code, mode and update count staying at their previous values. A following normal frame must then still be applied, which shows that the abort left the frame logic idle and ready.

// File: rtl/dacfe_pkg.sv
// Package: shared widths and the mode encoding for the serial DAC front end.
// Assumes the frame layout pad | mode | code, sent most significant bit first.
package dacfe_pkg;

    parameter int CODE_W  = 12;
    parameter int MODE_W  = 2;
    parameter int PAD_W   = 2;
    parameter int FRAME_W = PAD_W + MODE_W + CODE_W;
    parameter int PD_N    = (1 << MODE_W) - 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN  = 2'd0,
        MODE_PD_1 = 2'd1,
        MODE_PD_2 = 2'd2,
        MODE_PD_3 = 2'd3
    } op_mode_e;

endpackage

// File: rtl/dacfe_edge_sync.sv
// Module: multi-bit synchronizer with edge detection.
// Each bit passes through STAGES flops, then a history flop gives fell/rose.
// Assumes every input is asynchronous to clk and slow compared with it.
module dacfe_edge_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [2:0] RST_VAL = 3'b001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] fell_o,
    output logic [WIDTH-1:0] rose_o
);

    localparam logic [WIDTH-1:0] INIT = RST_VAL[WIDTH-1:0];

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] hist_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture stage from the asynchronous pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= INIT;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Further resolution stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= INIT;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // History flop used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= INIT;
        else        hist_q <= stage_q[STAGES-1];
    end

    assign level_o = stage_q[STAGES-1];
    assign fell_o  = hist_q & ~stage_q[STAGES-1];
    assign rose_o  = ~hist_q & stage_q[STAGES-1];

endmodule

// File: rtl/dacfe_frame_shifter.sv
// Module: frame tracker and input shift register.
// A frame opens on a strobe falling edge. Bits shift in on detected serial
// clock falls while the strobe is low. After FRAME_W bits, the word is
// presented with a one-cycle done pulse and the frame closes. A strobe that
// is high in any cycle, including one with a clock fall, closes the frame.
module dacfe_frame_shifter
    import dacfe_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_high_i,
    input  logic         strobe_fell_i,
    input  logic         sclk_fell_i,
    input  logic         din_i,
    output logic [W-1:0] word_o,
    output logic         done_o
);

    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     shift_q;
    logic [CNT_W-1:0] cnt_eff;
    logic             accept;
    logic [W-1:0]     shift_nx;

    // Bit count for this cycle (a fresh frame restarts at zero)
    always_comb cnt_eff = strobe_fell_i ? '0 : cnt_q;

    // A bit is taken only inside an open frame with the strobe low
    always_comb accept = !strobe_high_i && (armed_q || strobe_fell_i) && sclk_fell_i;

    // Shift register contents after taking the current bit
    always_comb shift_nx = {shift_q[W-2:0], din_i};

    // Frame state, bit counter and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            shift_q <= '0;
            word_o  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (strobe_high_i) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                if (strobe_fell_i) begin
                    armed_q <= 1'b1;
                    cnt_q   <= '0;
                end
                if (accept) begin
                    shift_q <= shift_nx;
                    if (cnt_eff == LAST) begin
                        armed_q <= 1'b0;
                        cnt_q   <= '0;
                        word_o  <= shift_nx;
                        done_o  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_eff + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dacfe_mode_regs.sv
// Module: code and mode registers with power-down decode.
// Loads the code and mode fields of a completed word on its done pulse and
// raises a one-cycle update strobe. Assumes the pad bits sit above the mode.
module dacfe_mode_regs
    import dacfe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               done_i,
    output logic [CODE_W-1:0]  code_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic               pd_active_o,
    output logic [PD_N-1:0]    pd_sel_o,
    output logic               update_o
);

    op_mode_e mode_q;

    // Register the fields of a completed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            mode_q   <= MODE_RUN;
            update_o <= 1'b0;
        end else begin
            update_o <= done_i;
            if (done_i) begin
                code_o <= word_i[CODE_W-1:0];
                mode_q <= op_mode_e'(word_i[CODE_W +: MODE_W]);
            end
        end
    end

    assign mode_o = mode_q;

    genvar m;
    generate
        for (m = 1; m <= PD_N; m++) begin : g_pd
            // One select line per power-down variant
            assign pd_sel_o[m-1] = (mode_q == op_mode_e'(m));
        end
    endgenerate

    // Any power-down variant selected
    assign pd_active_o = (mode_q != MODE_RUN);

endmodule

// File: rtl/dac_serial_front.sv
// Module: top of the serial DAC input register controller.
// Synchronizes the three serial wires, assembles frames and applies the
// code and mode. Assumes the serial clock half period spans at least three
// system clocks and the data is stable around each falling serial edge.
module dac_serial_front
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n_i,
    input  logic              sclk_i,
    input  logic              sdin_i,
    output logic [CODE_W-1:0] code_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              pd_active_o,
    output logic [PD_N-1:0]   pd_sel_o,
    output logic              update_o
);

    // Bit order inside the synchronized vector
    localparam int BIT_SYNC = 0;
    localparam int BIT_SCLK = 1;
    localparam int BIT_DIN  = 2;

    logic [2:0]         pin_lvl, pin_fell, pin_rose;
    logic [FRAME_W-1:0] word;
    logic               done;

    dacfe_edge_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdin_i, sclk_i, sync_n_i}),
        .level_o (pin_lvl),
        .fell_o  (pin_fell),
        .rose_o  (pin_rose)
    );

    dacfe_frame_shifter #(
        .W (FRAME_W)
    ) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_high_i (pin_lvl[BIT_SYNC]),
        .strobe_fell_i (pin_fell[BIT_SYNC]),
        .sclk_fell_i   (pin_fell[BIT_SCLK]),
        .din_i         (pin_lvl[BIT_DIN]),
        .word_o        (word),
        .done_o        (done)
    );

    dacfe_mode_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_i      (word),
        .done_i      (done),
        .code_o      (code_o),
        .mode_o      (mode_o),
        .pd_active_o (pd_active_o),
        .pd_sel_o    (pd_sel_o),
        .update_o    (update_o)
    );

    // Rising edges are only needed as a level change; keep them observed
    logic unused_rose;
    assign unused_rose = ^pin_rose;

endmodule

// File: rtl/dac_serial_front_chk.sv
// Module: checker for the serial DAC front end, bound to the top.
// Assumes a synchronous active-low reset.
module dac_serial_front_chk
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              pd_active_o,
    input logic [PD_N-1:0]   pd_sel_o,
    input logic              update_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (code_o == '0 && mode_o == '0 && !update_o));

    // R7
    update_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R7
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> ($stable(code_o) && $stable(mode_o)));

    // R4
    pd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pd_sel_o));

    // R4
    pd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == '0) |-> (!pd_active_o && pd_sel_o == '0));

    // R4
    pd_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != '0) |-> (pd_active_o && $countones(pd_sel_o) == 1));

endmodule

bind dac_serial_front dac_serial_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_o      (code_o),
    .mode_o      (mode_o),
    .pd_active_o (pd_active_o),
    .pd_sel_o    (pd_sel_o),
    .update_o    (update_o)
);

// File: tb/dac_serial_front_bench.sv
module dac_serial_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic [11:0] code;
    logic [1:0]  mode;
    logic        pd_active;
    logic [2:0]  pd_sel;
    logic        update;

    int checks = 0;
    int fails  = 0;
    int upd_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dac_serial_front u_dac_serial_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_n_i    (sync_n),
        .sclk_i      (sclk),
        .sdin_i      (sdin),
        .code_o      (code),
        .mode_o      (mode),
        .pd_active_o (pd_active),
        .pd_sel_o    (pd_sel),
        .update_o    (update)
    );

    // Count update pulses away from the active edge
    always @(negedge clk) if (rst_n && update) upd_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits of word (MSB first); rise_last lifts the strobe together
    // with the final falling clock; extra adds clock pulses before release
    task automatic send(input logic [15:0] word, input int nbits,
                        input bit rise_last, input int extra);
        @(negedge clk); sync_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1; sdin = word[15-i];
            wait_clk(3);
            sclk = 1'b0;
            if (rise_last && i == nbits - 1) sync_n = 1'b1;
            wait_clk(3);
        end
        for (int k = 0; k < extra; k++) begin
            sclk = 1'b1; sdin = ~sdin;
            wait_clk(3);
            sclk = 1'b0;
            wait_clk(3);
        end
        wait_clk(3);
        sync_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic expect_out(input string req, input int c, input int m);
        check(req, code, c);
        check(req, mode, m);
        check(req, pd_active, (m != 0) ? 1 : 0);
        check(req, pd_sel, (m == 0) ? 0 : (1 << (m - 1)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int exp_upd;
        int last_c, last_m;
        wait_clk(4);
        // R1: reset values
        expect_out("R1", 0, 0);
        check("R1 update", update, 0);
        rst_n = 1'b1;
        wait_clk(4);
        expect_out("R1", 0, 0);
        check("R1 upd_cnt", upd_cnt, 0);

        // R2 R3 R4 R7: sweep codes, all modes and pad patterns
        exp_upd = 0;
        for (int c = 0; c < 4096; c += 13) begin
            int m   = c % 4;
            int pad = (c / 4) % 4;
            send({pad[1:0], m[1:0], c[11:0]}, 16, 1'b0, 0);
            exp_upd++;
            expect_out("R2/R3/R4", c, m);
            check("R7 count", upd_cnt, exp_upd);
        end
        // R2: top code in every mode
        for (int m = 0; m < 4; m++) begin
            send({2'b11, m[1:0], 12'hFFF}, 16, 1'b0, 0);
            exp_upd++;
            expect_out("R2 max", 4095, m);
            check("R7 count", upd_cnt, exp_upd);
        end
        // R3: same code and mode with different pad bits
        send({2'b00, 2'b10, 12'h5A3}, 16, 1'b0, 0);
        exp_upd++;
        expect_out("R3 pad00", 12'h5A3, 2);
        send({2'b11, 2'b10, 12'h5A3}, 16, 1'b0, 0);
        exp_upd++;
        expect_out("R3 pad11", 12'h5A3, 2);
        check("R7 count", upd_cnt, exp_upd);
        last_c = 12'h5A3; last_m = 2;

        // R5: truncated frames of several lengths, checked mid-frame too
        for (int n = 1; n < 16; n += 2) begin
            @(negedge clk); sync_n = 1'b0;
            wait_clk(3);
            for (int i = 0; i < n; i++) begin
                sclk = 1'b1; sdin = (i % 2 == 0);
                wait_clk(3);
                sclk = 1'b0;
                wait_clk(3);
            end
            wait_clk(4);
            expect_out("R5 midframe", last_c, last_m);
            sync_n = 1'b1;
            wait_clk(6);
            expect_out("R5 discard", last_c, last_m);
            check("R5 no update", upd_cnt, exp_upd);
        end

        // R6: extra clock edges after the sixteenth are ignored
        send({2'b01, 2'b01, 12'h123}, 16, 1'b0, 7);
        exp_upd++;
        expect_out("R6", 12'h123, 1);
        check("R6 one update", upd_cnt, exp_upd);
        last_c = 12'h123; last_m = 1;

        // R8: clock activity with strobe high changes nothing
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); sclk = 1'b1; sdin = i[0];
            wait_clk(2);
            sclk = 1'b0;
            wait_clk(2);
        end
        wait_clk(6);
        expect_out("R8", last_c, last_m);
        check("R8 no update", upd_cnt, exp_upd);

        // R9: strobe rise coincides with the sixteenth falling clock
        send({2'b00, 2'b11, 12'hABC}, 16, 1'b1, 0);
        expect_out("R9 coincide", last_c, last_m);
        check("R9 no update", upd_cnt, exp_upd);
        // R9: block recovers for the next frame
        send({2'b00, 2'b11, 12'hABC}, 16, 1'b0, 0);
        exp_upd++;
        expect_out("R9 recover", 12'hABC, 3);
        check("R7 count", upd_cnt, exp_upd);

        // R2: back to normal mode and code zero
        send(16'h0000, 16, 1'b0, 0);
        exp_upd++;
        expect_out("R2 zero", 0, 0);
        check("R7 count", upd_cnt, exp_upd);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule